// File: doc/BRIEF.md
# Fractional M/N clock-enable generator with duty window

This block thins a stream of input enable strobes to an average of M output strobes for every N input strobes. It also drives a level output whose high time, counted in input strobes, is set by a duty value D. A controller presents three configuration fields and a one-cycle commit strobe. The fields are held in a compact encoding. The M field is the ratio numerator as is. The N field carries the bitwise inverse of N−M. The D field carries the bitwise inverse of the duty count. The block decodes these fields when it captures them.

When the decoded M equals the decoded N, the ratio is one and the block simply forwards every input strobe. Otherwise it runs a modulo-N accumulator. Each input strobe adds M, and each wrap past N gives one output strobe. A configuration that cannot be realised (M of zero, N of zero, or M above N) raises an error flag and silences both outputs. All outputs are registered, so an output responds one clock after the input strobe that caused it.

Top module: `mnd_clk_enable`

## Requirements
- R1: After a synchronous active-low reset, `en_out`, `duty_out`, `frac_active` and `cfg_err` are all 0, and the active configuration is M=0, N=0, D=0, which is pass-through.
- R2: On a clock edge where `commit` is 1, the block captures M = `m_field`, N = (~`n_field` + `m_field`) mod 2^CNT_W and D = ~`d_field`. Field changes without `commit` have no effect on the outputs.
- R3: When decoded M equals decoded N, the block is in pass-through. Every accepted `en_in` gives `en_out`=1 and `duty_out`=1 in the next cycle, and `frac_active` and `cfg_err` are both 0.
- R4: In fractional mode (M≠N, 0<M<N), each accepted `en_in` adds M to an accumulator that is cleared at commit. When the sum reaches N or more, N is subtracted and `en_out` is 1 in the next cycle. Over N strobes after a commit, exactly M pulses appear. `frac_active` is 1 in this mode.
- R5: If M≠N and M=0, N=0 or M>N, then `cfg_err` is 1, `frac_active` is 0, and `en_out` and `duty_out` stay 0 whatever `en_in` does.
- R6: In fractional mode a window counter runs from 0 to N−1 and is cleared at commit. Each accepted strobe first sets `duty_out` to (counter < D) and then advances the counter, wrapping at N. Between strobes `duty_out` holds. D=0 keeps it low, and D≥N keeps it high.
- R7: In a cycle with `commit`=1, a coincident `en_in` is discarded. `en_out` and `duty_out` are 0 in the following cycle, and the accumulator and the window counter restart from 0.
- R8: Without `en_in` in a cycle, `en_out` is 0 in the next cycle. In pass-through and error modes `duty_out` is 0 in that case as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_in | input | 1 | Input enable strobe |
| commit | input | 1 | Capture the configuration fields |
| m_field | input | CNT_W | Ratio numerator M |
| n_field | input | CNT_W | Inverse of N−M |
| d_field | input | CNT_W | Inverse of duty count D |
| en_out | output | 1 | Thinned enable strobe |
| duty_out | output | 1 | Duty-window level |
| frac_active | output | 1 | Fractional mode in use |
| cfg_err | output | 1 | Captured configuration is invalid |

## Verification
A commit and an input strobe can land in the same cycle. The commit must then win: the strobe is neither added nor forwarded, and counting restarts from the new configuration. The bench provokes this by raising `commit` together with `en_in` in both pass-through and fractional streams. A scoreboard model, built from the requirements, expects silence in the next cycle and a fresh M-of-N sequence afterwards. Any pulse that belongs to the dropped strobe shows up as a pulse or duty mismatch on the following strobes.

// File: rtl/mnd_pkg.sv
// Shared types for the fractional clock-enable generator.
package mnd_pkg;
    // Operating mode chosen from the captured configuration
    typedef enum logic [1:0] {
        MODE_PASS  = 2'd0,
        MODE_FRAC  = 2'd1,
        MODE_FAULT = 2'd2
    } mnd_mode_e;
endpackage

// File: rtl/mnd_cfg.sv
// Configuration capture: decodes the stored field encodings on commit and
// classifies the result into pass-through, fractional or fault mode.
// Assumes commit is a single-cycle strobe from the controller.
module mnd_cfg
    import mnd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [CNT_W-1:0] m_field,
    input  logic [CNT_W-1:0] n_field,
    input  logic [CNT_W-1:0] d_field,
    output logic [CNT_W-1:0] m_q,
    output logic [CNT_W-1:0] n_q,
    output logic [CNT_W-1:0] d_q,
    output mnd_mode_e        mode_q
);
    logic [CNT_W-1:0] m_dec, n_dec, d_dec;
    mnd_mode_e        mode_dec;

    // Decode the inverted encodings and pick the mode
    always_comb begin
        m_dec = m_field;
        n_dec = (~n_field) + m_field;
        d_dec = ~d_field;
        if (m_dec == n_dec)
            mode_dec = MODE_PASS;
        else if ((m_dec == '0) || (n_dec == '0) || (m_dec > n_dec))
            mode_dec = MODE_FAULT;
        else
            mode_dec = MODE_FRAC;
    end

    // Hold the active configuration; load only on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q    <= '0;
            n_q    <= '0;
            d_q    <= '0;
            mode_q <= MODE_PASS;
        end else if (commit) begin
            m_q    <= m_dec;
            n_q    <= n_dec;
            d_q    <= d_dec;
            mode_q <= mode_dec;
        end
    end

    AST_MODE_MATCHES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FRAC) |-> (m_q != '0 && m_q < n_q)); // R4
    AST_PASS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PASS) |-> (m_q == n_q)); // R3
endmodule

// File: rtl/mnd_accum.sv
// Rate accumulator: adds M per accepted strobe and emits one registered
// pulse each time the running sum reaches N. Assumes M < N in fractional
// mode, so the sum never exceeds 2N-1.
module mnd_accum
    import mnd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             en_in,
    input  mnd_mode_e        mode,
    input  logic [CNT_W-1:0] m_val,
    input  logic [CNT_W-1:0] n_val,
    output logic             pulse_q
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] acc_q;
    logic [SUM_W-1:0] sum;
    logic             wrap;

    // Next running sum and wrap decision
    always_comb begin
        sum  = {1'b0, acc_q} + {1'b0, m_val};
        wrap = (sum >= {1'b0, n_val});
    end

    // Accumulator and output pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            pulse_q <= 1'b0;
        end else if (commit) begin
            acc_q   <= '0;
            pulse_q <= 1'b0;
        end else if (en_in) begin
            unique case (mode)
                MODE_PASS: pulse_q <= 1'b1;
                MODE_FRAC: begin
                    pulse_q <= wrap;
                    acc_q   <= wrap ? CNT_W'(sum - {1'b0, n_val}) : CNT_W'(sum);
                end
                default:   pulse_q <= 1'b0;
            endcase
        end else begin
            pulse_q <= 1'b0;
        end
    end

    AST_ACC_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FRAC) |-> (acc_q < n_val)); // R4
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FAULT) |=> !pulse_q); // R5
endmodule

// File: rtl/mnd_duty.sv
// Duty window: counts accepted strobes modulo N and drives a level that is
// high for the first D strobes of each window. Level holds between strobes
// in fractional mode and follows the strobe in pass-through.
module mnd_duty
    import mnd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             en_in,
    input  mnd_mode_e        mode,
    input  logic [CNT_W-1:0] n_val,
    input  logic [CNT_W-1:0] d_val,
    output logic             level_q
);
    logic [CNT_W-1:0] win_q;
    logic [CNT_W-1:0] win_nxt;

    // Window counter successor with wrap at N
    always_comb begin
        win_nxt = (win_q == n_val - 1'b1) ? '0 : win_q + 1'b1;
    end

    // Window counter and level register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q   <= '0;
            level_q <= 1'b0;
        end else if (commit) begin
            win_q   <= '0;
            level_q <= 1'b0;
        end else if (en_in) begin
            unique case (mode)
                MODE_PASS: level_q <= 1'b1;
                MODE_FRAC: begin
                    level_q <= (win_q < d_val);
                    win_q   <= win_nxt;
                end
                default:   level_q <= 1'b0;
            endcase
        end else if (mode != MODE_FRAC) begin
            level_q <= 1'b0;
        end
    end

    AST_WIN_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FRAC) |-> (win_q < n_val)); // R6
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FRAC && !en_in && !commit) |=> $stable(level_q)); // R6
endmodule

// File: rtl/mnd_clk_enable.sv
// Top of the fractional M/N clock-enable generator. Ties the configuration
// capture, the rate accumulator and the duty window together. All outputs
// are registered; commit takes priority over a coincident input strobe.
module mnd_clk_enable
    import mnd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_in,
    input  logic             commit,
    input  logic [CNT_W-1:0] m_field,
    input  logic [CNT_W-1:0] n_field,
    input  logic [CNT_W-1:0] d_field,
    output logic             en_out,
    output logic             duty_out,
    output logic             frac_active,
    output logic             cfg_err
);
    logic [CNT_W-1:0] m_q, n_q, d_q;
    mnd_mode_e        mode_q;

    mnd_cfg #(.CNT_W(CNT_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .m_field(m_field), .n_field(n_field), .d_field(d_field),
        .m_q(m_q), .n_q(n_q), .d_q(d_q), .mode_q(mode_q)
    );

    mnd_accum #(.CNT_W(CNT_W)) accum_i (
        .clk(clk), .rst_n(rst_n), .commit(commit), .en_in(en_in),
        .mode(mode_q), .m_val(m_q), .n_val(n_q), .pulse_q(en_out)
    );

    mnd_duty #(.CNT_W(CNT_W)) duty_i (
        .clk(clk), .rst_n(rst_n), .commit(commit), .en_in(en_in),
        .mode(mode_q), .n_val(n_q), .d_val(d_q), .level_q(duty_out)
    );

    // Mode flags for the controller
    always_comb begin
        frac_active = (mode_q == MODE_FRAC);
        cfg_err     = (mode_q == MODE_FAULT);
    end

    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_in |=> !en_out); // R8
    AST_COMMIT_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (!en_out && !duty_out)); // R7
    AST_PASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en_in && !commit && mode_q == MODE_PASS) |=> (en_out && duty_out)); // R3
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!en_out && !duty_out)); // R5
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(frac_active && cfg_err)); // R2
endmodule

// File: tb/mnd_clk_enable_tb_top.sv
module mnd_clk_enable_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_in = 1'b0;
    logic commit = 1'b0;
    logic [W-1:0] m_field = '0;
    logic [W-1:0] n_field = '0;
    logic [W-1:0] d_field = '0;
    logic en_out, duty_out, frac_active, cfg_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    mnd_clk_enable #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_in(en_in), .commit(commit),
        .m_field(m_field), .n_field(n_field), .d_field(d_field),
        .en_out(en_out), .duty_out(duty_out),
        .frac_active(frac_active), .cfg_err(cfg_err)
    );

    int checks = 0;
    int errors = 0;
    int obs_pulses = 0;
    bit done = 1'b0;

    // Scoreboard queues: expected outputs and the requirement each judges
    logic [3:0] exp_q[$];
    string      ptag_q[$];
    string      ltag_q[$];

    // Reference model state (mode 0 pass, 1 fractional, 2 fault)
    int bm = 0, bn = 0, bd = 0, bacc = 0, bwin = 0, bmode = 0;
    bit blevel = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result
    task automatic step(input bit en, input bit cm, input int m, input int n, input int d);
        bit p;
        string pt, lt;
        @(negedge clk);
        en_in   = en;
        commit  = cm;
        if (cm) begin
            m_field = W'(m);
            n_field = ~W'(n - m);
            d_field = ~W'(d);
        end
        if (cm) begin
            bm = m & 255; bn = n & 255; bd = d & 255;
            if (bm == bn) bmode = 0;
            else if (bm == 0 || bn == 0 || bm > bn) bmode = 2;
            else bmode = 1;
            bacc = 0; bwin = 0; p = 0; blevel = 0;
            pt = "R7"; lt = "R7";
        end else if (en) begin
            if (bmode == 0) begin
                p = 1; blevel = 1; pt = "R3"; lt = "R3";
            end else if (bmode == 1) begin
                bacc = bacc + bm;
                p = (bacc >= bn);
                if (p) bacc = bacc - bn;
                blevel = (bwin < bd);
                bwin = (bwin + 1 == bn) ? 0 : bwin + 1;
                pt = "R4"; lt = "R6";
            end else begin
                p = 0; blevel = 0; pt = "R5"; lt = "R5";
            end
        end else begin
            p = 0;
            if (bmode != 1) blevel = 0;
            pt = "R8"; lt = (bmode == 1) ? "R6" : "R8";
        end
        exp_q.push_back({p, blevel, bmode == 1, bmode == 2});
        ptag_q.push_back(pt);
        ltag_q.push_back(lt);
    endtask

    // Fields change without commit: outputs must not react (R2)
    task automatic poke_fields(input int v);
        @(negedge clk);
        m_field = W'(v); n_field = W'(v * 3); d_field = W'(v * 7);
        en_in = 1'b0; commit = 1'b0;
        exp_q.push_back({1'b0, (bmode == 1) ? blevel : 1'b0, bmode == 1, bmode == 2});
        ptag_q.push_back("R2"); ltag_q.push_back("R2");
        if (bmode != 1) blevel = 0;
    endtask

    task automatic drain();
        @(negedge clk);
        en_in = 1'b0; commit = 1'b0;
        exp_q.push_back({1'b0, (bmode == 1) ? blevel : 1'b0, bmode == 1, bmode == 2});
        ptag_q.push_back("R8"); ltag_q.push_back("R8");
        if (bmode != 1) blevel = 0;
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    // Monitor: pop and compare one expected item per clock
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [3:0] e;
                string pt, lt;
                e = exp_q.pop_front();
                pt = ptag_q.pop_front();
                lt = ltag_q.pop_front();
                if (en_out) obs_pulses++;
                check(en_out == e[3], pt, "en_out", en_out, e[3]);
                check(duty_out == e[2], lt, "duty_out", duty_out, e[2]);
                check(frac_active == e[1], "R2", "frac_active", frac_active, e[1]);
                check(cfg_err == e[0], "R2", "cfg_err", cfg_err, e[0]);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int start;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(en_out == 0 && duty_out == 0, "R1", "outputs after reset",
              {en_out, duty_out}, 0);
        check(frac_active == 0 && cfg_err == 0, "R1", "flags after reset",
              {frac_active, cfg_err}, 0);

        // R3/R8: default pass-through with a gapped strobe pattern
        step(1, 0, 0, 0, 0); step(0, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0); step(0, 0, 0, 0, 0);

        // R4/R6: M=3, N=8, D=4, continuous strobes over two windows
        step(0, 1, 3, 8, 4);
        drain();
        start = obs_pulses;
        for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0);
        drain();
        check(obs_pulses - start == 6, "R4", "pulses in 16 strobes at 3/8",
              obs_pulses - start, 6);

        // R2: fields move without commit, then gapped strobes keep 3/8
        poke_fields(17); poke_fields(90);
        for (int i = 0; i < 16; i++) step(i % 3 != 1, 0, 0, 0, 0);

        // R7: commit coinciding with a strobe, M=2, N=5, D=2
        step(1, 1, 2, 5, 2);
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0);
        // R7: commit with strobe while in pass-through
        step(1, 1, 5, 5, 1);
        step(1, 0, 0, 0, 0); step(1, 1, 1, 4, 0);
        for (int i = 0; i < 8; i++) step(1, 0, 0, 0, 0);

        // R6: D beyond N keeps level high
        step(0, 1, 1, 4, 255);
        for (int i = 0; i < 9; i++) step(i != 4, 0, 0, 0, 0);

        // R5: fault configurations
        step(0, 1, 0, 6, 3);
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0);
        step(0, 1, 7, 3, 3);
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0);

        // R4: large ratio near width limit, M=254, N=255
        step(0, 1, 254, 255, 100);
        drain();
        start = obs_pulses;
        for (int i = 0; i < 255; i++) step(1, 0, 0, 0, 0);
        drain();
        check(obs_pulses - start == 254, "R4", "pulses in 255 strobes at 254/255",
              obs_pulses - start, 254);

        drain();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule